// File: doc/BRIEF.md
# Eight-Ring Transmit Fetch Arbiter

This block decides which of eight transmit descriptor rings the DMA fetch engine reads from next. The fetch path reports back with two strobes aimed at the ring that is currently granted. One strobe says a frame completed and gives its byte length. The other says the descriptor just read was not ready. A 2-bit mode input picks the arbitration scheme: a single polled ring, strict lowest-index priority, or a weighted round-robin that charges each ring's turn against a byte budget.

A ring that runs dry, or every enabled ring after an error, is marked in an eight-bit halt register. Software clears that register by writing ones, and a halted ring stays out of arbitration until its bit is cleared.

In round-robin mode each ring keeps a signed deficit counter. At the start of each turn, weight×64 is added to the counter. Each completed frame subtracts its length. A turn ends when the counter reaches zero or below, so any overshoot is carried into the ring's next turn.

Top module: `txq_arbiter`

## Requirements
- R1: After reset every halt bit is 0, and with no ring enabled `grant_vld_o` is 0.
- R2: In mode 2'b00, and in the reserved mode 2'b11, only ring 0 is granted. `grant_idx_o` is 0 and `grant_vld_o` is high exactly when ring 0 is enabled and not halted.
- R3: In mode 2'b00 two not-ready strobes on ring 0 are treated as retries and leave its halt bit clear. The third consecutive one sets halt bit 0. A frame-done strobe restarts the count.
- R4: In mode 2'b01 the grant is the lowest-index ring that is enabled and not halted.
- R5: In modes 2'b01 and 2'b10 a not-ready strobe sets the halt bit of the granted ring, and arbitration then moves to another eligible ring.
- R6: Writing a 1 to bit i of `halt_w1c_i` clears halt bit i, and writing a 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R7: An error strobe sets the halt bit of every enabled ring and leaves the halt bits of disabled rings unchanged.
- R8: When no ring is eligible, `grant_vld_o` is 0, and a valid grant always names a ring that is enabled and not halted.
- R9: In mode 2'b10, a new turn costs one cycle with `grant_vld_o` low. In that cycle the ring's counter gains weight×64 (weight from bits [8i+7:8i] of `weight_i`). The ring stays granted while its counter stays above 0 after each frame. Turns pass to the next eligible ring in ascending cyclic order.
- R10: In mode 2'b10 the overshoot below zero is kept for the next turn. A ring whose carried counter plus quota is still 0 or less is skipped for that round, which costs one more load cycle.
- R11: A strobe changes the grant only after the next clock edge. In the cycle it is applied, the grant still shows the old ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Arbitration scheme: 00 polled, 01 priority, 10 weighted round-robin, 11 as 00 |
| ring_en_i | input | 8 | Per-ring enable |
| weight_i | input | 64 | Per-ring 8-bit weights, ring i in bits [8i+7:8i] |
| done_i | input | 1 | Frame completed on the granted ring |
| frame_len_i | input | 16 | Byte length of the completed frame |
| not_ready_i | input | 1 | Fetched descriptor of the granted ring was not ready |
| err_i | input | 1 | DMA error, halts all enabled rings |
| halt_w1c_i | input | 8 | Write-one-to-clear strobe for the halt bits |
| grant_idx_o | output | 3 | Granted ring index |
| grant_vld_o | output | 1 | Grant is valid |
| halt_o | output | 8 | Per-ring halt status |

## Verification
A deficit counter that drifts shows up at the ports within one turn. The ring then keeps the grant for too many or too few frames, or a skip appears or disappears, all visible on `grant_idx_o`/`grant_vld_o` one cycle after the deciding frame-done strobe. A wrong halt bit shows on `halt_o` on the cycle after the strobe, and it also changes the priority grant in that same cycle. A miscounted retry in polled mode sets halt bit 0 one strobe early or late.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
  typedef enum logic [1:0] {
    MODE_POLL = 2'b00,
    MODE_PRIO = 2'b01,
    MODE_WRR  = 2'b10,
    MODE_RSVD = 2'b11
  } txq_mode_e;

  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_SERVE = 1'b1
  } txq_phase_e;
endpackage

// File: rtl/txq_halt.sv
`timescale 1ns/1ps
module txq_halt #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         err_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] halt_o
);
  logic [N-1:0] halt_q;
  logic [N-1:0] set_all;

  assign set_all = set_i | ({N{err_i}} & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= '0;
    else         halt_q <= (halt_q & ~clr_i) | set_all;
  end

  assign halt_o = halt_q;

  // R7
  err_halts_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> ((halt_q & $past(en_i)) == $past(en_i)));

  // R6
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i & ~({N{err_i}} & en_i)) != '0) |=>
      ((halt_q & $past(clr_i & ~set_i & ~({N{err_i}} & en_i))) == '0));
endmodule

// File: rtl/txq_prio_pick.sv
`timescale 1ns/1ps
module txq_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/txq_wrr.sv
`timescale 1ns/1ps
module txq_wrr
  import txq_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N),
  parameter int WT_W  = 8,
  parameter int LEN_W = 16,
  parameter int Q_SH  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [N-1:0]     elig_i,
  input  logic [N*WT_W-1:0] weight_i,
  input  logic             done_i,
  input  logic             empty_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] cur_o,
  output logic             serve_o
);
  localparam int QW    = WT_W + Q_SH;
  localparam int DEF_W = ((QW > LEN_W) ? QW : LEN_W) + 2;

  txq_phase_e              phase_q;
  logic [IDX_W-1:0]        cur_q, nxt;
  logic signed [DEF_W-1:0] def_q [N];
  logic signed [DEF_W-1:0] quota [N];
  logic signed [DEF_W-1:0] loaded, charged;

  for (genvar g = 0; g < N; g++) begin : g_quota
    assign quota[g] = $signed({{(DEF_W-QW){1'b0}}, weight_i[g*WT_W +: WT_W], {Q_SH{1'b0}}});
  end

  // next eligible ring after cur_q in cyclic order, cur_q itself last
  always_comb begin
    nxt = cur_q;
    for (int k = N; k >= 1; k--) begin
      if (elig_i[(int'(cur_q) + k) % N]) nxt = IDX_W'((int'(cur_q) + k) % N);
    end
  end

  assign loaded  = def_q[cur_q] + quota[cur_q];
  assign charged = def_q[cur_q] - $signed({{(DEF_W-LEN_W){1'b0}}, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      cur_q   <= '0;
      for (int i = 0; i < N; i++) def_q[i] <= '0;
    end else if (!active_i) begin
      phase_q <= PH_LOAD;
    end else if (phase_q == PH_LOAD) begin
      if (elig_i[cur_q]) begin
        def_q[cur_q] <= loaded;
        if (loaded > 0) phase_q <= PH_SERVE;
        else            cur_q   <= nxt;
      end else begin
        cur_q <= nxt;
      end
    end else begin
      if (!elig_i[cur_q]) begin
        cur_q   <= nxt;
        phase_q <= PH_LOAD;
      end else if (empty_i) begin
        def_q[cur_q] <= '0;
        cur_q        <= nxt;
        phase_q      <= PH_LOAD;
      end else if (done_i) begin
        def_q[cur_q] <= charged;
        if (charged <= 0) begin
          cur_q   <= nxt;
          phase_q <= PH_LOAD;
        end
      end
    end
  end

  assign cur_o   = cur_q;
  assign serve_o = (phase_q == PH_SERVE) && elig_i[cur_q];

  // R9
  turn_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && phase_q == PH_SERVE && elig_i[cur_q] && !done_i && !empty_i) |=>
      (phase_q == PH_SERVE && $stable(cur_q)));
endmodule

// File: rtl/txq_arbiter.sv
`timescale 1ns/1ps
module txq_arbiter
  import txq_pkg::*;
#(
  parameter int N     = 8,
  parameter int WT_W  = 8,
  parameter int LEN_W = 16,
  parameter int Q_SH  = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [N-1:0]      ring_en_i,
  input  logic [N*WT_W-1:0] weight_i,
  input  logic              done_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              not_ready_i,
  input  logic              err_i,
  input  logic [N-1:0]      halt_w1c_i,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              grant_vld_o,
  output logic [N-1:0]      halt_o
);
  localparam int RETRY_MAX = 2;

  txq_mode_e        mode;
  logic             m_poll, m_prio, m_wrr;
  logic [N-1:0]     elig, halt_set;
  logic [IDX_W-1:0] prio_idx, wrr_idx;
  logic             prio_any, wrr_serve;
  logic [1:0]       retry_q;
  logic             stb_empty, stb_done;

  assign mode   = txq_mode_e'(mode_i);
  assign m_prio = (mode == MODE_PRIO);
  assign m_wrr  = (mode == MODE_WRR);
  assign m_poll = !m_prio && !m_wrr;
  assign elig   = ring_en_i & ~halt_o;

  txq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req_i (elig),
    .idx_o (prio_idx),
    .any_o (prio_any)
  );

  txq_wrr #(.N(N), .IDX_W(IDX_W), .WT_W(WT_W), .LEN_W(LEN_W), .Q_SH(Q_SH)) u_wrr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (m_wrr),
    .elig_i   (elig),
    .weight_i (weight_i),
    .done_i   (stb_done),
    .empty_i  (stb_empty),
    .len_i    (frame_len_i),
    .cur_o    (wrr_idx),
    .serve_o  (wrr_serve)
  );

  always_comb begin
    if (m_prio) begin
      grant_idx_o = prio_idx;
      grant_vld_o = prio_any;
    end else if (m_wrr) begin
      grant_idx_o = wrr_idx;
      grant_vld_o = wrr_serve;
    end else begin
      grant_idx_o = '0;
      grant_vld_o = elig[0];
    end
  end

  assign stb_empty = not_ready_i && grant_vld_o;
  assign stb_done  = done_i && grant_vld_o;

  // polled ring: retries before declaring ring 0 empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          retry_q <= '0;
    else if (!m_poll || stb_done)         retry_q <= '0;
    else if (stb_empty)                   retry_q <= (retry_q == 2'(RETRY_MAX)) ? '0 : retry_q + 2'd1;
  end

  always_comb begin
    halt_set = '0;
    if (stb_empty) begin
      if (!m_poll)                             halt_set = {{(N-1){1'b0}}, 1'b1} << grant_idx_o;
      else if (retry_q == 2'(RETRY_MAX))       halt_set[0] = 1'b1;
    end
  end

  txq_halt #(.N(N)) u_halt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (halt_set),
    .clr_i  (halt_w1c_i),
    .err_i  (err_i),
    .en_i   (ring_en_i),
    .halt_o (halt_o)
  );

  // R2
  poll_ring0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> (grant_idx_o == '0));

  // R8
  grant_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> (ring_en_i[grant_idx_o] && !halt_o[grant_idx_o]));

  // R5
  not_ready_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && not_ready_i && (mode_i == 2'b01 || mode_i == 2'b10)) |=>
      halt_o[$past(grant_idx_o)]);
endmodule

// File: tb/txq_arbiter_tb.sv
`timescale 1ns/1ps
module txq_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  en = '0;
  logic [63:0] weight = '0;
  logic        done = 1'b0;
  logic [15:0] len = '0;
  logic        nrdy = 1'b0;
  logic        err = 1'b0;
  logic [7:0]  w1c = '0;
  logic [2:0]  gidx;
  logic        gvld;
  logic [7:0]  halt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  txq_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ring_en_i(en), .weight_i(weight),
    .done_i(done), .frame_len_i(len), .not_ready_i(nrdy), .err_i(err),
    .halt_w1c_i(w1c), .grant_idx_o(gidx), .grant_vld_o(gvld), .halt_o(halt)
  );

  // {mode, enables, expected index, expected valid}
  localparam logic [13:0] VEC [8] = '{
    {2'b00, 8'hFF, 3'd0, 1'b1},
    {2'b00, 8'hFE, 3'd0, 1'b0},
    {2'b11, 8'h06, 3'd0, 1'b0},
    {2'b11, 8'h01, 3'd0, 1'b1},
    {2'b01, 8'hF0, 3'd4, 1'b1},
    {2'b01, 8'h0A, 3'd1, 1'b1},
    {2'b01, 8'h80, 3'd7, 1'b1},
    {2'b01, 8'h00, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_grant(input string req, input logic [2:0] ei, input logic ev);
    chk({req, " vld"}, 32'(gvld), 32'(ev));
    if (ev) chk({req, " idx"}, 32'(gidx), 32'(ei));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // strobes applied for one cycle, cleared at the following negedge
  task automatic pulse(input logic d, input logic [15:0] l, input logic nr,
                       input logic e, input logic [7:0] c);
    done = d; len = l; nrdy = nr; err = e; w1c = c;
    step();
    done = 1'b0; len = '0; nrdy = 1'b0; err = 1'b0; w1c = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1
    chk("R1 halt", 32'(halt), 32'h0);
    chk("R1 vld", 32'(gvld), 32'h0);

    // R2 R4 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][13:12];
      en   = VEC[i][11:4];
      #5;
      chk_grant("R2/R4/R8 table", VEC[i][3:1], VEC[i][0]);
      @(negedge clk);
    end

    // R3 retries in polled mode
    mode = 2'b00; en = 8'h01;
    @(negedge clk);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    chk("R3 first", 32'(halt), 32'h00);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    chk("R3 second", 32'(halt), 32'h00);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    chk("R3 third", 32'(halt), 32'h01);
    chk("R3 vld", 32'(gvld), 32'h0);
    pulse(1'b0, '0, 1'b0, 1'b0, 8'h01);
    chk("R6 clear ring0", 32'(halt), 32'h00);
    // done restarts the count
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    pulse(1'b1, 16'd64, 1'b0, 1'b0, '0);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    chk("R3 restart", 32'(halt), 32'h00);
    pulse(1'b0, '0, 1'b0, 1'b0, '0);

    // priority mode: not-ready with simultaneous clear, set wins
    mode = 2'b01; en = 8'h0F;
    @(negedge clk);
    chk_grant("R4 start", 3'd0, 1'b1);
    nrdy = 1'b1; w1c = 8'h01;
    #5;
    chk_grant("R11 before edge", 3'd0, 1'b1);
    @(negedge clk);
    nrdy = 1'b0; w1c = '0;
    chk("R6 set wins", 32'(halt), 32'h01);
    chk_grant("R5 moves on", 3'd1, 1'b1);
    pulse(1'b0, '0, 1'b0, 1'b0, 8'h02);
    chk("R6 zero bit no effect", 32'(halt), 32'h01);
    pulse(1'b0, '0, 1'b0, 1'b0, 8'h01);
    chk("R6 clear", 32'(halt), 32'h00);
    chk_grant("R4 back", 3'd0, 1'b1);

    // R7 error
    pulse(1'b0, '0, 1'b0, 1'b1, '0);
    chk("R7 halts", 32'(halt), 32'h0F);
    chk_grant("R8 none", 3'd0, 1'b0);
    en = 8'h30;
    #5;
    chk_grant("R7 disabled rings untouched", 3'd4, 1'b1);
    @(negedge clk);
    pulse(1'b0, '0, 1'b0, 1'b0, 8'hFF);
    chk("R6 clear all", 32'(halt), 32'h00);

    // weighted round-robin: ring0 weight 1 (64B), ring1 weight 2 (128B)
    weight = {48'h0, 8'd2, 8'd1};
    mode = 2'b10; en = 8'h03;
    step();
    chk_grant("R9 ring0 turn", 3'd0, 1'b1);
    pulse(1'b1, 16'd100, 1'b0, 1'b0, '0);   // def0 -36
    chk_grant("R9 load gap", 3'd0, 1'b0);
    step();                                  // def1 128
    chk_grant("R9 ring1 turn", 3'd1, 1'b1);
    pulse(1'b1, 16'd60, 1'b0, 1'b0, '0);     // 68
    chk_grant("R9 hold 1", 3'd1, 1'b1);
    pulse(1'b1, 16'd60, 1'b0, 1'b0, '0);     // 8
    chk_grant("R9 hold 2", 3'd1, 1'b1);
    pulse(1'b1, 16'd60, 1'b0, 1'b0, '0);     // -52
    chk_grant("R9 end turn", 3'd0, 1'b0);
    step();                                  // def0 28
    chk_grant("R10 carry ring0", 3'd0, 1'b1);
    pulse(1'b1, 16'd100, 1'b0, 1'b0, '0);   // -72
    step();                                  // def1 76
    chk_grant("R10 carry ring1", 3'd1, 1'b1);
    pulse(1'b1, 16'd200, 1'b0, 1'b0, '0);   // -124
    chk_grant("R9 gap", 3'd0, 1'b0);
    step();                                  // def0 -8: skipped
    chk_grant("R10 skip", 3'd0, 1'b0);
    step();                                  // def1 4
    chk_grant("R10 after skip", 3'd1, 1'b1);
    pulse(1'b0, '0, 1'b1, 1'b0, '0);
    chk("R5 wrr halt", 32'(halt), 32'h02);
    chk_grant("R5 wrr gap", 3'd0, 1'b0);
    step();                                  // def0 56
    chk_grant("R5 wrr next", 3'd0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule